// File: doc/BRIEF.md
# Serial Memory Status Register and Write Protection

This block is the slave-side status logic of a serial memory on an SPI bus (mode 0: clock idles low, data sampled on rising edges, driven on falling edges). It decodes four 8-bit instructions from the bus: latch-set, latch-clear, status read and status write. It keeps a write-enable latch, a busy flag, two protect-level bits and a status-lock bit. The protect and lock bits stand in for non-volatile cells and are modelled as registers. The SPI pins are oversampled by a fast system clock through synchronizers, so the SPI clock must run several times slower than `clk`.

The lock bit combines with an active-low write-protect pin. When the lock bit is 1 and the pin is low, the protect and lock bits are frozen and status writes are dropped. A status read may be issued at any time, including while an internal write is running. It streams the status byte repeatedly for as long as chip select stays low.

An external array-write engine uses a start/acknowledge/done handshake. The block grants a start only when the latch is set, nothing is busy and the target address lies outside the protected region. It then holds the busy flag until the engine reports done.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the output enable `spi_miso_en` is 0, `arr_wr_ack` and `arr_wr_allowed` are 0, and a status read returns 0x00.
- R2: Status byte layout: bit 7 is the lock bit, bits 3:2 are the protect level, bit 1 is the write-enable latch, bit 0 is busy, and bits 6:4 read 0. Opcode 0x05 (bits sampled on rising SPI clock edges, MSB first) starts a read. The byte is then driven MSB first, each bit changing after a falling SPI clock edge.
- R3: While chip select stays low after a read opcode, the status byte is sent again and again, refreshed at every byte boundary.
- R4: Opcode 0x06 sets the latch and opcode 0x04 clears it. Each acts only when chip select rises after exactly 8 bits and the busy flag is 0.
- R5: Opcode 0x01 followed by exactly 8 data bits and a chip-select rise writes data bit 7 to the lock bit and data bits 3:2 to the protect level. This happens only when the latch is 1, the block is not busy and the protected mode is off. Busy then reads 1 for `STW_CYCLES` clock cycles, after which busy and the latch both clear.
- R6: A status write with any data length other than 8 bits leaves the status unchanged.
- R7: When the lock bit is 1 and `wp_n` is 0, a status write is ignored. The lock bit, the protect level and the latch keep their values.
- R8: The status can be read while a write is running, and shows busy = 1 with the latch still set.
- R9: Protect decode for an address width `ADDR_W`: level 01 protects the upper quarter, 10 the upper half, 11 everything, and 00 nothing. `arr_addr_prot` gives the decode of `arr_wr_addr` one clock later.
- R10: `arr_wr_start` is acknowledged by a one-cycle `arr_wr_ack` only when the latch is 1, the block is not busy and the address is not protected. Busy then stays 1 until `arr_wr_done`, at which point busy and the latch clear. `arr_wr_allowed` reads latch AND NOT busy.
- R11: `spi_miso_en` is 0 except during the data phase of a status read. It drops once chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| spi_miso_en | output | 1 | Output enable for the data line's tri-state buffer |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_wr_start | input | 1 | Array engine requests a write |
| arr_wr_addr | input | ADDR_W | Target address of the requested write |
| arr_wr_done | input | 1 | Array engine reports the end of its write |
| arr_wr_ack | output | 1 | One-cycle grant of a write request |
| arr_wr_allowed | output | 1 | Latch set and not busy |
| arr_addr_prot | output | 1 | `arr_wr_addr` is in the protected region |

## Verification
The assertions assume that chip select, the SPI clock and write protect are slow compared with `clk`. Each level must hold for several system cycles so that the synchronizers see every edge. They also assume that `arr_wr_done` arrives only while an accepted array write is running. The stimulus keeps SPI half periods at eight system cycles and changes data and chip select only while the SPI clock is low. It raises `arr_wr_done` only after an acknowledged start. Write protect is changed only between transactions.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam logic [7:0] OP_SET_LATCH = 8'h06;
  localparam logic [7:0] OP_CLR_LATCH = 8'h04;
  localparam logic [7:0] OP_RD_STAT   = 8'h05;
  localparam logic [7:0] OP_WR_STAT   = 8'h01;

  localparam int BITCNT_W = 5;

  typedef enum logic {BUSY_STAT = 1'b0, BUSY_ARR = 1'b1} busy_kind_t;

  function automatic logic [7:0] pack_status(input logic lock, input logic [1:0] lvl,
                                             input logic latch, input logic busy);
    return {lock, 3'b000, lvl, latch, busy};
  endfunction
endpackage

// File: rtl/stat_pin_sync.sv
module stat_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else if (g == 0) chain[g] <= d;
      else chain[g] <= chain[(g == 0) ? 0 : g - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stat_cmd_rx.sv
module stat_cmd_rx
  import stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csn_s,
  input  logic       sck_s,
  input  logic       mosi_s,
  output logic       rd_mode,
  output logic       sck_fall,
  output logic       ev_set,
  output logic       ev_clr,
  output logic       ev_wst,
  output logic       wst_lock,
  output logic [1:0] wst_lvl
);
  logic                sck_q, csn_q;
  logic [BITCNT_W-1:0] bitcnt;
  logic [7:0]          shreg, opcode;
  logic                sck_rise, cs_rise;
  localparam logic [BITCNT_W-1:0] CNT_MAX = '1;

  assign sck_rise = sck_s & ~sck_q & ~csn_s;
  assign sck_fall = ~sck_s & sck_q & ~csn_s;
  assign cs_rise  = csn_s & ~csn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
      bitcnt   <= '0;
      shreg    <= '0;
      opcode   <= '0;
      rd_mode  <= 1'b0;
      ev_set   <= 1'b0;
      ev_clr   <= 1'b0;
      ev_wst   <= 1'b0;
      wst_lock <= 1'b0;
      wst_lvl  <= '0;
    end else begin
      sck_q  <= sck_s;
      csn_q  <= csn_s;
      ev_set <= 1'b0;
      ev_clr <= 1'b0;
      ev_wst <= 1'b0;
      if (csn_s) begin
        if (cs_rise) begin
          ev_set   <= (bitcnt == BITCNT_W'(8))  && (opcode == OP_SET_LATCH);
          ev_clr   <= (bitcnt == BITCNT_W'(8))  && (opcode == OP_CLR_LATCH);
          ev_wst   <= (bitcnt == BITCNT_W'(16)) && (opcode == OP_WR_STAT);
          wst_lock <= shreg[7];
          wst_lvl  <= shreg[3:2];
        end
        bitcnt  <= '0;
        rd_mode <= 1'b0;
      end else if (sck_rise) begin
        shreg <= {shreg[6:0], mosi_s};
        if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BITCNT_W'(7)) begin
          opcode  <= {shreg[6:0], mosi_s};
          rd_mode <= ({shreg[6:0], mosi_s} == OP_RD_STAT);
        end
      end
    end
  end
endmodule

// File: rtl/stat_tx.sv
module stat_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       csn_s,
  input  logic       rd_mode,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_en
);
  logic [7:0] txsh;
  logic [2:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh    <= '0;
      left    <= '0;
      miso    <= 1'b0;
      miso_en <= 1'b0;
    end else if (csn_s) begin
      left    <= '0;
      miso    <= 1'b0;
      miso_en <= 1'b0;
    end else if (rd_mode && sck_fall) begin
      miso_en <= 1'b1;
      if (left == 3'd0) begin
        miso <= status[7];
        txsh <= {status[6:0], 1'b0};
        left <= 3'd7;
      end else begin
        miso <= txsh[7];
        txsh <= {txsh[6:0], 1'b0};
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stat_prot_dec.sv
module stat_prot_dec #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] SPAN     = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] HALF_LO  = SPAN >> 1;
  localparam logic [ADDR_W:0] QUART_LO = SPAN - (SPAN >> 2);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    unique case (lvl)
      2'b01:   hit = (a_ext >= QUART_LO);
      2'b10:   hit = (a_ext >= HALF_LO);
      2'b11:   hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/stat_regs.sv
module stat_regs
  import stat_pkg::*;
#(
  parameter int STW_CYCLES = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_set,
  input  logic       ev_clr,
  input  logic       ev_wst,
  input  logic       wst_lock,
  input  logic [1:0] wst_lvl,
  input  logic       wp_s,
  input  logic       arr_start,
  input  logic       arr_hit,
  input  logic       arr_done,
  output logic       lock_q,
  output logic [1:0] lvl_q,
  output logic       latch_q,
  output logic       busy_q,
  output logic       ack_q,
  output logic       allowed_q
);
  localparam int TMR_W = (STW_CYCLES > 1) ? $clog2(STW_CYCLES) : 1;

  logic [TMR_W-1:0] tmr;
  busy_kind_t       kind;
  logic             hw_lock;

  assign hw_lock = lock_q & ~wp_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= 1'b0;
      lvl_q     <= '0;
      latch_q   <= 1'b0;
      busy_q    <= 1'b0;
      ack_q     <= 1'b0;
      allowed_q <= 1'b0;
      tmr       <= '0;
      kind      <= BUSY_STAT;
    end else begin
      ack_q     <= 1'b0;
      allowed_q <= latch_q & ~busy_q;
      if (busy_q) begin
        if (kind == BUSY_STAT) begin
          if (tmr == '0) begin
            busy_q  <= 1'b0;
            latch_q <= 1'b0;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end else if (arr_done) begin
          busy_q  <= 1'b0;
          latch_q <= 1'b0;
        end
      end else begin
        if (ev_set) latch_q <= 1'b1;
        if (ev_clr) latch_q <= 1'b0;
        if (ev_wst && latch_q && !hw_lock) begin
          lock_q <= wst_lock;
          lvl_q  <= wst_lvl;
          busy_q <= 1'b1;
          kind   <= BUSY_STAT;
          tmr    <= TMR_W'(STW_CYCLES - 1);
        end else if (arr_start && latch_q && !arr_hit) begin
          busy_q <= 1'b1;
          kind   <= BUSY_ARR;
          ack_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
  import stat_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int STW_CYCLES  = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  input  logic              wp_n,
  input  logic              arr_wr_start,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  input  logic              arr_wr_done,
  output logic              arr_wr_ack,
  output logic              arr_wr_allowed,
  output logic              arr_addr_prot
);
  logic       csn_s, sck_s, mosi_s, wp_s;
  logic       rd_mode, sck_fall, ev_set, ev_clr, ev_wst, wst_lock;
  logic [1:0] wst_lvl;
  logic       srwd_q, wel_q, wip_q;
  logic [1:0] bp_q;
  logic       prot_hit;
  logic [7:0] status;

  stat_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sck, spi_mosi, wp_n}),
    .q({csn_s, sck_s, mosi_s, wp_s})
  );

  stat_cmd_rx u_rx (
    .clk(clk), .rst(rst), .csn_s(csn_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .rd_mode(rd_mode), .sck_fall(sck_fall), .ev_set(ev_set), .ev_clr(ev_clr),
    .ev_wst(ev_wst), .wst_lock(wst_lock), .wst_lvl(wst_lvl)
  );

  stat_prot_dec #(.ADDR_W(ADDR_W)) u_dec (
    .lvl(bp_q), .addr(arr_wr_addr), .hit(prot_hit)
  );

  stat_regs #(.STW_CYCLES(STW_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_clr(ev_clr), .ev_wst(ev_wst),
    .wst_lock(wst_lock), .wst_lvl(wst_lvl), .wp_s(wp_s),
    .arr_start(arr_wr_start), .arr_hit(prot_hit), .arr_done(arr_wr_done),
    .lock_q(srwd_q), .lvl_q(bp_q), .latch_q(wel_q), .busy_q(wip_q),
    .ack_q(arr_wr_ack), .allowed_q(arr_wr_allowed)
  );

  assign status = pack_status(srwd_q, bp_q, wel_q, wip_q);

  stat_tx u_tx (
    .clk(clk), .rst(rst), .csn_s(csn_s), .rd_mode(rd_mode), .sck_fall(sck_fall),
    .status(status), .miso(spi_miso), .miso_en(spi_miso_en)
  );

  always_ff @(posedge clk) begin
    if (rst) arr_addr_prot <= 1'b0;
    else     arr_addr_prot <= prot_hit;
  end
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       csn_s,
  input logic       wp_s,
  input logic       spi_miso_en,
  input logic       srwd_q,
  input logic [1:0] bp_q,
  input logic       wel_q,
  input logic       wip_q,
  input logic       arr_wr_ack
);
  // R11: output enable falls once chip select is seen high
  p_hiz_idle_r11: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !spi_miso_en);

  // R7: protected mode freezes lock and protect bits
  p_hw_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (srwd_q && !wp_s) |=> $stable({srwd_q, bp_q}));

  // R4: no write of any kind starts without the latch
  p_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    (!wel_q && !wip_q) |=> !wip_q);

  // R5: latch is clear when a write cycle ends
  p_latch_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(wip_q) |-> !wel_q);

  // R10: a grant only follows a set latch with nothing running
  p_ack_ok_r10: assert property (@(posedge clk) disable iff (rst)
    arr_wr_ack |-> $past(wel_q && !wip_q));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .csn_s(csn_s), .wp_s(wp_s), .spi_miso_en(spi_miso_en),
  .srwd_q(srwd_q), .bp_q(bp_q), .wel_q(wel_q), .wip_q(wip_q), .arr_wr_ack(arr_wr_ack)
);

// File: tb/spi_status_ctrl_tb.sv
`timescale 1ns/1ps
module spi_status_ctrl_tb;
  localparam int ADDR_W = 11;
  localparam int STW    = 1500;
  localparam int HP     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
  logic arr_wr_start = 1'b0, arr_wr_done = 1'b0;
  logic [ADDR_W-1:0] arr_wr_addr = '0;
  logic spi_miso, spi_miso_en, arr_wr_ack, arr_wr_allowed, arr_addr_prot;

  spi_status_ctrl #(.ADDR_W(ADDR_W), .STW_CYCLES(STW)) u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_en(spi_miso_en), .wp_n(wp_n),
    .arr_wr_start(arr_wr_start), .arr_wr_addr(arr_wr_addr), .arr_wr_done(arr_wr_done),
    .arr_wr_ack(arr_wr_ack), .arr_wr_allowed(arr_wr_allowed), .arr_addr_prot(arr_addr_prot)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_v[$];
  string      exp_tag[$];
  bit         finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      wait_clk(HP);
      spi_sck = 1'b1;
      wait_clk(HP);
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_xfer(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2);
    spi_cs_n = 1'b0;
    wait_clk(HP);
    spi_byte(b0);
    if (nb > 1) spi_byte(b1);
    if (nb > 2) spi_byte(b2);
    wait_clk(HP);
    spi_cs_n = 1'b1;
    wait_clk(4 * HP);
  endtask

  // driver: queues the expected bytes, then clocks the read
  task automatic spi_read(input int nb, input logic [7:0] e, input string tag);
    for (int k = 0; k < nb; k++) begin
      exp_v.push_back(e);
      exp_tag.push_back(tag);
    end
    spi_cs_n = 1'b0;
    wait_clk(HP);
    spi_byte(8'h05);
    check(spi_miso_en == 1'b0, "R11 enable low during opcode", spi_miso_en, 0);
    for (int k = 0; k < nb; k++) spi_byte(8'h00);
    wait_clk(HP);
    spi_cs_n = 1'b1;
    wait_clk(4 * HP);
    check(spi_miso_en == 1'b0, "R11 enable low after deselect", spi_miso_en, 0);
    check(exp_v.size() == 0, "R3 all queued bytes received", exp_v.size(), 0);
  endtask

  // monitor: assembles bytes on rising SPI clock and compares
  initial begin
    logic [7:0] acc = '0;
    int nbit = 0;
    forever begin
      @(posedge spi_sck);
      if (spi_miso_en) begin
        acc = {acc[6:0], spi_miso};
        nbit++;
        if (nbit == 8) begin
          nbit = 0;
          if (exp_v.size() == 0) begin
            check(1'b0, "R2 unexpected status byte", acc, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_v.pop_front();
            t = exp_tag.pop_front();
            check(acc == e, t, acc, e);
          end
        end
      end
    end
  end

  task automatic arr_start(input logic [ADDR_W-1:0] a, input bit exp_ack, input string tag);
    arr_wr_addr = a;
    wait_clk(2);
    arr_wr_start = 1'b1;
    wait_clk(1);
    arr_wr_start = 1'b0;
    check(arr_wr_ack == exp_ack, tag, arr_wr_ack, exp_ack);
    wait_clk(1);
    check(arr_wr_ack == 1'b0, "R10 ack lasts one cycle", arr_wr_ack, 0);
  endtask

  task automatic prot_at(input logic [ADDR_W-1:0] a, input bit exp, input string tag);
    arr_wr_addr = a;
    wait_clk(2);
    check(arr_addr_prot == exp, tag, arr_addr_prot, exp);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    check(spi_miso_en == 1'b0, "R1 enable after reset", spi_miso_en, 0);
    check(arr_wr_allowed == 1'b0, "R1 allowed after reset", arr_wr_allowed, 0);
    check(arr_wr_ack == 1'b0, "R1 ack after reset", arr_wr_ack, 0);
    spi_read(1, 8'h00, "R1 status after reset");
    prot_at(11'h7FF, 1'b0, "R9 level 00 protects nothing");

    spi_xfer(1, 8'h06, 8'h00, 8'h00);
    spi_read(1, 8'h02, "R4 set latch");
    check(arr_wr_allowed == 1'b1, "R10 allowed with latch", arr_wr_allowed, 1);
    spi_xfer(1, 8'h04, 8'h00, 8'h00);
    spi_read(1, 8'h00, "R4 clear latch");

    // status write: lock=1, level=11; read twice while busy
    spi_xfer(1, 8'h06, 8'h00, 8'h00);
    spi_xfer(2, 8'h01, 8'h8C, 8'h00);
    spi_read(2, 8'h8F, "R8 R3 busy stream");
    wait_clk(STW + 100);
    spi_read(1, 8'h8C, "R5 write done, latch cleared");

    // protected mode
    wp_n = 1'b0;
    wait_clk(8);
    spi_xfer(1, 8'h06, 8'h00, 8'h00);
    spi_xfer(2, 8'h01, 8'h00, 8'h00);
    wait_clk(50);
    spi_read(1, 8'h8E, "R7 write ignored when locked");
    prot_at(11'h000, 1'b1, "R9 level 11 protects all");
    arr_start(11'h000, 1'b0, "R10 no grant on protected address");

    // unlock via pin, write level 01
    wp_n = 1'b1;
    wait_clk(8);
    spi_xfer(2, 8'h01, 8'h04, 8'h00);
    spi_read(1, 8'h07, "R5 accepted when pin high");
    wait_clk(STW + 100);
    spi_read(1, 8'h04, "R5 new level in place");

    // wrong lengths
    spi_xfer(1, 8'h06, 8'h00, 8'h00);
    spi_xfer(3, 8'h01, 8'h08, 8'h08);
    spi_xfer(1, 8'h01, 8'h00, 8'h00);
    wait_clk(50);
    spi_read(1, 8'h06, "R6 wrong length ignored");

    prot_at(11'h5FF, 1'b0, "R9 level 01 below upper quarter");
    prot_at(11'h600, 1'b1, "R9 level 01 upper quarter");

    // array write handshake
    arr_start(11'h100, 1'b1, "R10 grant");
    wait_clk(2);
    check(arr_wr_allowed == 1'b0, "R10 not allowed while busy", arr_wr_allowed, 0);
    spi_read(1, 8'h07, "R8 read during array write");
    arr_wr_done = 1'b1;
    wait_clk(1);
    arr_wr_done = 1'b0;
    wait_clk(4);
    spi_read(1, 8'h04, "R10 done clears busy and latch");
    arr_start(11'h100, 1'b0, "R10 no grant without latch");

    // level 10
    spi_xfer(1, 8'h06, 8'h00, 8'h00);
    spi_xfer(2, 8'h01, 8'h08, 8'h00);
    wait_clk(STW + 100);
    spi_read(1, 8'h08, "R2 level 10 layout");
    prot_at(11'h3FF, 1'b0, "R9 level 10 lower half");
    prot_at(11'h400, 1'b1, "R9 level 10 upper half");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule